// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address into a physical address through a small segment table held in registers. The logical address has two fields, a segment number and an offset. Each table entry stores a base address, a length, a present flag and a write-enable flag. A separate register holds the highest segment number in use.

A request passes through four checks in a fixed priority order: the segment number, the present flag, the length and the write permission. When all four pass, the block adds the entry's base to the offset and returns that sum with a zero status code. When any check fails, it returns a nonzero status code that names the first failed check, and the physical address is zero.

Translation takes one registered stage with valid/ready handshakes on both sides. A privileged port loads the table and the highest-segment register. That port stalls while a translation result is waiting in the output stage. A write changes the behaviour of requests accepted from the next cycle onward.

Top module: `segxlat`

## Requirements
- R1: After reset, rspValid is 0, reqReady is 1 and cfgReady is 1. Every table entry is not present, and the highest-segment register holds 0.
- R2: A request whose segment number is greater than the highest-segment register returns status code 1 (segment out of range).
- R3: A request to a segment whose present flag is 0 returns status code 3 (entry not present).
- R4: A request whose offset is greater than or equal to the entry's length returns status code 2 (limit exceeded). A segment of length 0 therefore rejects every offset.
- R5: A write request (reqWrite=1) to an entry whose write-enable flag is 0 returns status code 4 (write protected). A read request to the same entry is translated normally.
- R6: When several checks fail, the code returned is the first failed check in this order: segment range (1), present (3), limit (2), write protection (4).
- R7: When no check fails, the status code is 0 and rspPhys equals (base + offset) modulo 2^PHYS_BITS. When a check fails, rspPhys is 0.
- R8: A request accepted on a clock edge (reqValid and reqReady both high) appears with rspValid=1 after that edge. The result holds stable while rspReady is low. reqReady is high exactly when the output stage is empty or is being drained.
- R9: While rspValid is 1, cfgReady is 0. A table write or highest-segment write attempted during that time is ignored.
- R10: A table write accepted on an edge does not affect a request accepted on the same edge. It does affect every request accepted on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Request accepted on this edge when high |
| reqSeg | input | SEG_BITS | Segment number |
| reqOff | input | OFF_BITS | Offset within segment |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rspValid | output | 1 | Translation result present |
| rspReady | input | 1 | Consumer takes the result |
| rspPhys | output | PHYS_BITS | Physical address (0 on a trap) |
| rspTrap | output | 3 | Status: 0 ok, 1 segment range, 2 limit, 3 not present, 4 write protected |
| cfgReady | output | 1 | Configuration writes are accepted when high |
| cfgWrEn | input | 1 | Write one table entry |
| cfgWrIdx | input | SEG_BITS | Entry index for the write |
| cfgWrBase | input | PHYS_BITS | New base address |
| cfgWrLen | input | OFF_BITS+1 | New length in address units |
| cfgWrPresent | input | 1 | New present flag |
| cfgWrWritable | input | 1 | New write-enable flag |
| cfgTopWe | input | 1 | Write the highest-segment register |
| cfgTopVal | input | SEG_BITS | Highest valid segment number |

## Verification
The assertions assume that the consumer follows the handshake: rspReady may be held low for any number of cycles, and requests arrive only when reqReady allows them. They also assume that reset is applied before the first request. The bench drives every input at the falling edge and keeps reqValid low except during its own accepted transfers. It issues configuration writes either while the output stage is empty or, on purpose, during a stall to confirm that they are ignored. The random offsets cluster around each segment's length, so the strict limit comparison is exercised at its edge.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

  // strobes from control to the datapath and the table
  typedef struct packed {
    logic capture;   // load the output stage with a new result
    logic tblWrite;  // commit one table entry
    logic topWrite;  // commit the highest-segment register
  } xlStrobe_t;

  typedef enum logic [2:0] {
    TRAP_NONE      = 3'd0,
    TRAP_SEG_RANGE = 3'd1,
    TRAP_LIMIT     = 3'd2,
    TRAP_ABSENT    = 3'd3,
    TRAP_WRPROT    = 3'd4
  } trapCode_t;

endpackage

// File: rtl/segxlat_table.sv
module segxlat_table
  import segxlat_pkg::*;
#(
  parameter int SEG_BITS  = 3,
  parameter int OFF_BITS  = 13,
  parameter int PHYS_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xlStrobe_t            strobe,
  input  logic                 inFlight,
  input  logic [SEG_BITS-1:0]  wrIdx,
  input  logic [PHYS_BITS-1:0] wrBase,
  input  logic [OFF_BITS:0]    wrLen,
  input  logic                 wrPresent,
  input  logic                 wrWritable,
  input  logic [SEG_BITS-1:0]  topVal,
  input  logic [SEG_BITS-1:0]  rdIdx,
  output logic [PHYS_BITS-1:0] rdBase,
  output logic [OFF_BITS:0]    rdLen,
  output logic                 rdPresent,
  output logic                 rdWritable,
  output logic [SEG_BITS-1:0]  topSeg
);

  localparam int NSEG  = 1 << SEG_BITS;
  localparam int LEN_W = OFF_BITS + 1;

  logic [NSEG-1:0][PHYS_BITS-1:0] baseQ;
  logic [NSEG-1:0][LEN_W-1:0]     lenQ;
  logic [NSEG-1:0]                presentQ;
  logic [NSEG-1:0]                writableQ;
  logic [SEG_BITS-1:0]            topQ;

  for (genvar g = 0; g < NSEG; g++) begin : gEntry
    logic hit;
    assign hit = strobe.tblWrite && (wrIdx == SEG_BITS'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g]     <= '0;
        lenQ[g]      <= '0;
        presentQ[g]  <= 1'b0;
        writableQ[g] <= 1'b0;
      end else if (hit) begin
        baseQ[g]     <= wrBase;
        lenQ[g]      <= wrLen;
        presentQ[g]  <= wrPresent;
        writableQ[g] <= wrWritable;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                topQ <= '0;
    else if (strobe.topWrite) topQ <= topVal;
  end

  assign rdBase     = baseQ[rdIdx];
  assign rdLen      = lenQ[rdIdx];
  assign rdPresent  = presentQ[rdIdx];
  assign rdWritable = writableQ[rdIdx];
  assign topSeg     = topQ;

  // R9: nothing in the table moves while a result waits in the output stage
  a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |=> ($stable(baseQ) && $stable(lenQ) && $stable(presentQ)
                  && $stable(writableQ) && $stable(topQ)));

endmodule

// File: rtl/segxlat_ctrl.sv
module segxlat_ctrl
  import segxlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rspReady,
  input  logic       cfgWrEn,
  input  logic       cfgTopWe,
  output logic       reqReady,
  output logic       rspValid,
  output logic       cfgReady,
  output xlStrobe_t  strobe
);

  logic busyQ;

  assign reqReady = !busyQ || rspReady;
  assign cfgReady = !busyQ;
  assign rspValid = busyQ;

  always_comb begin
    strobe          = '0;
    strobe.capture  = reqValid && reqReady;
    strobe.tblWrite = cfgWrEn && cfgReady;
    strobe.topWrite = cfgTopWe && cfgReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               busyQ <= 1'b0;
    else if (strobe.capture) busyQ <= 1'b1;
    else if (rspReady)       busyQ <= 1'b0;
  end

  // R8: an accepted request always produces a result next cycle
  a_r8_accept_to_result: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R8: an undrained result stays
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

endmodule

// File: rtl/segxlat_datapath.sv
module segxlat_datapath
  import segxlat_pkg::*;
#(
  parameter int SEG_BITS  = 3,
  parameter int OFF_BITS  = 13,
  parameter int PHYS_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xlStrobe_t            strobe,
  input  logic                 rspValid,
  input  logic                 rspReady,
  input  logic [SEG_BITS-1:0]  reqSeg,
  input  logic [OFF_BITS-1:0]  reqOff,
  input  logic                 reqWrite,
  input  logic [PHYS_BITS-1:0] entBase,
  input  logic [OFF_BITS:0]    entLen,
  input  logic                 entPresent,
  input  logic                 entWritable,
  input  logic [SEG_BITS-1:0]  topSeg,
  output logic [PHYS_BITS-1:0] rspPhys,
  output logic [2:0]           rspTrap
);

  localparam int LEN_W = OFF_BITS + 1;

  logic           segOver;
  logic           limitOver;
  logic           wrDenied;
  trapCode_t      trapNext;
  logic [PHYS_BITS-1:0] sumNext;
  logic [PHYS_BITS-1:0] physNext;
  logic [PHYS_BITS-1:0] physQ;
  trapCode_t      trapQ;

  assign segOver   = reqSeg > topSeg;
  assign limitOver = LEN_W'(reqOff) >= entLen;
  assign wrDenied  = reqWrite && !entWritable;
  assign sumNext   = entBase + PHYS_BITS'(reqOff);

  // fixed priority: range, presence, limit, protection
  always_comb begin
    if (segOver)          trapNext = TRAP_SEG_RANGE;
    else if (!entPresent) trapNext = TRAP_ABSENT;
    else if (limitOver)   trapNext = TRAP_LIMIT;
    else if (wrDenied)    trapNext = TRAP_WRPROT;
    else                  trapNext = TRAP_NONE;
  end

  assign physNext = (trapNext == TRAP_NONE) ? sumNext : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physQ <= '0;
      trapQ <= TRAP_NONE;
    end else if (strobe.capture) begin
      physQ <= physNext;
      trapQ <= trapNext;
    end
  end

  assign rspPhys = physQ;
  assign rspTrap = trapQ;

  // R8: a stalled result does not change
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspPhys) && $stable(rspTrap)));

  // R7: a trapped result carries no address
  a_r7_zero_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTrap != 3'd0) |-> (rspPhys == '0));

  // R4: a zero-length present segment in range never translates
  a_r4_zero_length: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !segOver && entPresent && entLen == '0)
      |=> (rspTrap == 3'd2));

  // R6: out-of-range segment wins over every other check
  a_r6_range_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && segOver) |=> (rspTrap == 3'd1));

endmodule

// File: rtl/segxlat.sv
module segxlat
  import segxlat_pkg::*;
#(
  parameter int SEG_BITS  = 3,
  parameter int OFF_BITS  = 13,
  parameter int PHYS_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [SEG_BITS-1:0]  reqSeg,
  input  logic [OFF_BITS-1:0]  reqOff,
  input  logic                 reqWrite,
  output logic                 rspValid,
  input  logic                 rspReady,
  output logic [PHYS_BITS-1:0] rspPhys,
  output logic [2:0]           rspTrap,
  output logic                 cfgReady,
  input  logic                 cfgWrEn,
  input  logic [SEG_BITS-1:0]  cfgWrIdx,
  input  logic [PHYS_BITS-1:0] cfgWrBase,
  input  logic [OFF_BITS:0]    cfgWrLen,
  input  logic                 cfgWrPresent,
  input  logic                 cfgWrWritable,
  input  logic                 cfgTopWe,
  input  logic [SEG_BITS-1:0]  cfgTopVal
);

  xlStrobe_t            strobe;
  logic [PHYS_BITS-1:0] entBase;
  logic [OFF_BITS:0]    entLen;
  logic                 entPresent;
  logic                 entWritable;
  logic [SEG_BITS-1:0]  topSeg;

  segxlat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .cfgWrEn  (cfgWrEn),
    .cfgTopWe (cfgTopWe),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .cfgReady (cfgReady),
    .strobe   (strobe)
  );

  segxlat_table #(
    .SEG_BITS (SEG_BITS),
    .OFF_BITS (OFF_BITS),
    .PHYS_BITS(PHYS_BITS)
  ) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inFlight   (rspValid),
    .wrIdx      (cfgWrIdx),
    .wrBase     (cfgWrBase),
    .wrLen      (cfgWrLen),
    .wrPresent  (cfgWrPresent),
    .wrWritable (cfgWrWritable),
    .topVal     (cfgTopVal),
    .rdIdx      (reqSeg),
    .rdBase     (entBase),
    .rdLen      (entLen),
    .rdPresent  (entPresent),
    .rdWritable (entWritable),
    .topSeg     (topSeg)
  );

  segxlat_datapath #(
    .SEG_BITS (SEG_BITS),
    .OFF_BITS (OFF_BITS),
    .PHYS_BITS(PHYS_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .reqSeg      (reqSeg),
    .reqOff      (reqOff),
    .reqWrite    (reqWrite),
    .entBase     (entBase),
    .entLen      (entLen),
    .entPresent  (entPresent),
    .entWritable (entWritable),
    .topSeg      (topSeg),
    .rspPhys     (rspPhys),
    .rspTrap     (rspTrap)
  );

endmodule

// File: tb/sim_segxlat.sv
module sim_segxlat;

  localparam int SB = 3;
  localparam int OB = 13;
  localparam int PB = 18;
  localparam int NS = 1 << SB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [SB-1:0] reqSeg = '0;
  logic [OB-1:0] reqOff = '0;
  logic          reqWrite = 1'b0;
  logic          rspValid;
  logic          rspReady = 1'b1;
  logic [PB-1:0] rspPhys;
  logic [2:0]    rspTrap;
  logic          cfgReady;
  logic          cfgWrEn = 1'b0;
  logic [SB-1:0] cfgWrIdx = '0;
  logic [PB-1:0] cfgWrBase = '0;
  logic [OB:0]   cfgWrLen = '0;
  logic          cfgWrPresent = 1'b0;
  logic          cfgWrWritable = 1'b0;
  logic          cfgTopWe = 1'b0;
  logic [SB-1:0] cfgTopVal = '0;

  always #10 clk = ~clk;  // 50 MHz

  segxlat u0 (.*);

  // reference model of the table
  logic [PB-1:0] mBase [NS];
  logic [OB:0]   mLen  [NS];
  bit            mPres [NS];
  bit            mWrit [NS];
  int            mTop;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic int expTrap(int s, int o, bit w);
    if (s > mTop) return 1;
    if (!mPres[s]) return 3;
    if (o >= int'(mLen[s])) return 2;
    if (w && !mWrit[s]) return 4;
    return 0;
  endfunction

  function automatic int expPhys(int s, int o, bit w);
    if (expTrap(s, o, w) != 0) return 0;
    return int'((mBase[s] + PB'(o)) & {PB{1'b1}});
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doXlate(int s, int o, bit w, string tag);
    int et, ep;
    @(negedge clk);
    et = expTrap(s, o, w);
    ep = expPhys(s, o, w);
    reqValid = 1'b1; reqSeg = SB'(s); reqOff = OB'(o); reqWrite = w;
    rspReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R8 rspValid"}, int'(rspValid), 1);
    chk({tag, " trap"}, int'(rspTrap), et);
    chk({tag, " R7 phys"}, int'(rspPhys), ep);
  endtask

  task automatic cfgEntry(int i, int b, int l, bit p, bit wr);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = SB'(i); cfgWrBase = PB'(b);
    cfgWrLen = (OB+1)'(l); cfgWrPresent = p; cfgWrWritable = wr;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mBase[i] = PB'(b); mLen[i] = (OB+1)'(l); mPres[i] = p; mWrit[i] = wr;
  endtask

  task automatic cfgTop(int t);
    @(negedge clk);
    cfgTopWe = 1'b1; cfgTopVal = SB'(t);
    @(negedge clk);
    cfgTopWe = 1'b0;
    mTop = t;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      mBase[i] = '0; mLen[i] = '0; mPres[i] = 0; mWrit[i] = 0;
    end
    mTop = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", int'(rspValid), 0);
    chk("R1 reqReady", int'(reqReady), 1);
    chk("R1 cfgReady", int'(cfgReady), 1);
    doXlate(0, 0, 0, "R1 seg0 absent R3");
    doXlate(1, 0, 0, "R1 top=0 R2");

    // populate
    cfgTop(5);
    cfgEntry(0, 'h01000, 'h100, 1, 1);
    cfgEntry(1, 'h3FFF0, 'h2000, 1, 0);
    cfgEntry(2, 'h08000, 0, 1, 1);
    cfgEntry(3, 'h10000, 'h40, 0, 1);
    cfgEntry(6, 'h20000, 'h80, 1, 1);

    doXlate(0, 'hFF, 0, "R4 last legal");
    doXlate(0, 'h100, 0, "R4 at limit");
    doXlate(2, 0, 0, "R4 zero length");
    doXlate(3, 0, 0, "R3 absent");
    doXlate(1, 5, 1, "R5 write protect");
    doXlate(1, 5, 0, "R5 read ok");
    doXlate(1, 'h1FFF, 0, "R7 wrap");
    doXlate(6, 0, 0, "R2 above top");
    doXlate(3, 'h1000, 1, "R6 absent over limit");
    doXlate(1, 'h1FFF, 1, "R6 limit ok then wrprot");
    doXlate(2, 0, 1, "R6 limit before wrprot");
    doXlate(7, 'h1FFF, 1, "R6 range first");

    // R9 and R8: writes blocked while a result is held
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 3'd0; reqOff = 13'h10; reqWrite = 1'b0;
    rspReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 cfgReady busy", int'(cfgReady), 0);
    chk("R8 reqReady busy", int'(reqReady), 0);
    cfgWrEn = 1'b1; cfgWrIdx = 3'd0; cfgWrBase = 18'h2AAAA;
    cfgWrLen = 14'd1; cfgWrPresent = 1'b0; cfgWrWritable = 1'b0;
    cfgTopWe = 1'b1; cfgTopVal = 3'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 stall valid", int'(rspValid), 1);
      chk("R8 stall phys", int'(rspPhys), 'h01010);
      chk("R8 stall trap", int'(rspTrap), 0);
    end
    cfgWrEn = 1'b0; cfgTopWe = 1'b0;
    rspReady = 1'b1;
    @(negedge clk);
    chk("R8 drained", int'(rspValid), 0);
    doXlate(0, 'h20, 0, "R9 entry unchanged");
    doXlate(5, 0, 0, "R9 top unchanged");

    // R10: write and request on the same edge
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = 3'd0; cfgWrBase = 18'h05000;
    cfgWrLen = 14'h200; cfgWrPresent = 1'b1; cfgWrWritable = 1'b1;
    reqValid = 1'b1; reqSeg = 3'd0; reqOff = 13'h150; reqWrite = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk("R10 same edge trap", int'(rspTrap), expTrap(0, 'h150, 0));
    chk("R10 same edge phys", int'(rspPhys), expPhys(0, 'h150, 0));
    mBase[0] = 18'h05000; mLen[0] = 14'h200; mPres[0] = 1; mWrit[0] = 1;
    doXlate(0, 'h150, 0, "R10 next edge");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int pick = $urandom_range(0, 9);
      if (pick == 0) begin
        cfgEntry($urandom_range(0, NS-1), $urandom_range(0, (1<<PB)-1),
                 $urandom_range(0, 1<<OB), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 1));
      end else if (pick == 1) begin
        cfgTop($urandom_range(0, NS-1));
      end else begin
        int s = $urandom_range(0, NS-1);
        int o;
        if ($urandom_range(0, 1) == 1) begin
          o = int'(mLen[s]) + $urandom_range(0, 2) - 1;
          if (o < 0) o = 0;
          if (o > (1<<OB)-1) o = (1<<OB)-1;
        end else begin
          o = $urandom_range(0, (1<<OB)-1);
        end
        doXlate(s, o, $urandom_range(0, 1), "R2-R7 random");
      end
    end
    repeat (2) @(negedge clk);
    summary();
  end

endmodule